// File: doc/BRIEF.md
# Selectable-Order MASH Dither Modulator

This block takes a 5-bit fractional frequency word and turns it into a small set of dither enables for a digitally controlled oscillator. Over time, the average number of active enables tracks the fraction, so the oscillator reaches a frequency resolution finer than one oscillator step. The block is a cascade of three accumulator stages in MASH form. The carries of the stages pass through difference networks that cancel the quantisation error of the earlier stages.

The order can be changed at run time through `order`: 0 = off, 1 = first order, 2 = second order, 3 = third order. A stage whose index is above the selected order is frozen and adds nothing to the output. Selecting off clears the whole modulator. The block runs on the pre-scaled oscillator clock, which is one quarter or one eighth of the output frequency. The fractional word comes from a slower loop that updates only on some of those edges. The word is registered on every edge, so a word that is held steady between updates is always taken cleanly.

The signed modulator level is also brought out as a port. The enables are given as a thermometer code around a mid-scale count of three.

Top module: `mash_dither`

## Requirements
- R1: While and after reset, before any non-zero order has been applied, `level` is 0 and `dither_en` is 7'b0000111 (mid-scale, three enables).
- R2: `frac_word` is registered on every clock edge. The word present at edge k first enters the stage arithmetic at edge k+1. `level` shows the result after that edge. So from a cleared first-order state, a step from 0 to 16 gives `level` 0 after the second edge and 1 after the third edge.
- R3: Stage k (k = 1..3) runs when `order` ≥ k. Each stage adds its input to its 5-bit accumulator, keeping the low 5 bits and producing a carry from bit 5. Stage 1 adds the registered word. Stage 2 adds the new residue of stage 1, and stage 3 adds the new residue of stage 2. `level` = c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' marks the value from that stage's previous run. A stage's terms count only while it runs.
- R4: With `order` = 0, every accumulator and delay register is cleared at the edge, and `level` becomes 0 (mid-scale enables), whatever `frac_word` is.
- R5: At first order, starting from a cleared state with a constant word x, the sum of `level` over the next 32 outputs equals x exactly.
- R6: `level` lies in {0,1} after an edge with `order` = 1, in −1..2 with `order` = 2, and in −3..4 with `order` = 3.
- R7: `dither_en` is a thermometer code. Its lowest 3 + `level` bits are set and all others are clear.
- R8: A stage that is not running holds its accumulator and its delay registers. When the order is raised again, the stage resumes from the held values.
- R9: From a cleared state with a constant word x, over N outputs, |32·Σlevel − N·x| ≤ 31 at orders 1 and 2, and ≤ 62 at order 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pre-scaled oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| order | input | 2 | Modulator order: 0 off, 1..3 |
| frac_word | input | 5 | Fractional frequency word from the loop filter |
| level | output | 4 | Signed modulator level, two's complement |
| dither_en | output | 7 | Thermometer dither enables, 3 + level bits set |

## Verification
An order change can arrive on the same edge as a change of the fractional word. That edge must stop or restart stages while the word register takes a new value and the remaining stages keep accumulating. The bench provokes this on purpose: it changes both inputs at the same falling edge, and it holds and resumes stages in mid-sequence. An arithmetic model of the cascade, built from the equations in the requirements, judges every output cycle. Sweeps over all 32 words at each order check the long-run average against the word.

// File: rtl/mash_pkg.sv
// Shared constants for the selectable-order MASH dither modulator.
// Assumes the cascade depth is fixed at three stages; the output
// code widths and the mid-scale point are derived from that depth.
package mash_pkg;
    localparam int STAGES   = 3;
    localparam int LVL_W    = 4;
    localparam int DITHER_N = (1 << STAGES) - 1;
    localparam int MID      = (1 << (STAGES - 1)) - 1;
    typedef logic signed [LVL_W-1:0] level_t;
endpackage

// File: rtl/mash_stage.sv
// One accumulator stage of the cascade.
// Adds add_in to its accumulator when run is high. It produces a carry
// out of the top bit and the new residue, which feeds the next stage
// in the same cycle. Assumes clear and run are never needed together:
// clear has priority. When run is low the accumulator holds and the
// carry is forced low.
module mash_stage #(
    parameter int ACC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [ACC_W-1:0] add_in,
    output logic             carry,
    output logic [ACC_W-1:0] resid
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    // Full-width sum of the stored residue and the incoming word
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, add_in};
        carry = run & sum[ACC_W];
        resid = sum[ACC_W-1:0];
    end

    // Accumulator register: cleared, advanced, or held
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/mash_combine.sv
// Noise-cancellation network.
// Differences the stage-2 carry once and the stage-3 carry twice,
// adds the stage-1 carry, and registers the signed level. Each
// stage's delay registers advance only while that stage runs, so a
// frozen stage contributes nothing and resumes from its held history.
module mash_combine
    import mash_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [STAGES-1:0]  run,
    input  logic [STAGES-1:0]  carry,
    output level_t             level
);
    logic   c2_d, c3_d, c3_dd;
    int     sum_i;
    level_t level_d;

    // Combine the carries of the running stages into one signed value
    always_comb begin
        sum_i = run[0] ? int'(carry[0]) : 0;
        if (run[1]) sum_i = sum_i + int'(carry[1]) - int'(c2_d);
        if (run[2]) sum_i = sum_i + int'(carry[2]) - 2 * int'(c3_d) + int'(c3_dd);
        level_d = level_t'(sum_i);
    end

    // Carry history and level register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
            level <= '0;
        end else begin
            level <= level_d;
            if (run[1]) c2_d <= carry[1];
            if (run[2]) begin
                c3_d  <= carry[2];
                c3_dd <= c3_d;
            end
        end
    end
endmodule

// File: rtl/dither_therm.sv
// Converts the signed level into a thermometer of dither enables
// centred on the mid-scale count. Purely combinational; assumes the
// level never leaves -MID..DITHER_N-MID.
module dither_therm
    import mash_pkg::*;
(
    input  level_t              level,
    output logic [DITHER_N-1:0] dither_en
);
    int fill;

    // Number of enables to set
    always_comb fill = MID + int'(level);

    for (genvar i = 0; i < DITHER_N; i++) begin : g_bit
        // One enable: set while its index is below the fill count
        always_comb dither_en[i] = (i < fill);
    end
endmodule

// File: rtl/mash_dither.sv
// Selectable-order MASH dither modulator, top level.
// Registers the fractional word on every edge, because the slower
// loop keeps the word stable between its own updates. The word drives
// a chain of accumulator stages whose run enables come from the
// requested order, and the stage carries are combined into a level
// and a thermometer. Order 0 clears all state and holds mid-scale.
module mash_dither
    import mash_pkg::*;
#(
    parameter int ACC_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          order,
    input  logic [ACC_W-1:0]    frac_word,
    output logic [LVL_W-1:0]    level,
    output logic [DITHER_N-1:0] dither_en
);
    logic [ACC_W-1:0]  frac_q;
    logic [ACC_W-1:0]  chain [STAGES+1];
    logic [STAGES-1:0] run;
    logic [STAGES-1:0] carry;
    logic              clear;
    level_t            level_q;

    // Capture the word on every pre-scaled edge
    always_ff @(posedge clk) begin
        if (!rst_n) frac_q <= '0;
        else        frac_q <= frac_word;
    end

    // Off request and stage head
    always_comb begin
        clear    = (order == 2'd0);
        chain[0] = frac_q;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        // Run enable of stage k+1
        always_comb run[k] = (int'(order) > k);

        mash_stage #(.ACC_W(ACC_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run[k]),
            .clear  (clear),
            .add_in (chain[k]),
            .carry  (carry[k]),
            .resid  (chain[k+1])
        );
    end

    mash_combine u_combine (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .run   (run),
        .carry (carry),
        .level (level_q)
    );

    dither_therm u_therm (
        .level     (level_q),
        .dither_en (dither_en)
    );

    // Level to port
    always_comb level = level_q;
endmodule

// File: rtl/mash_dither_chk.sv
// Checker for the MASH dither modulator: relates the order input, the
// level port and the enable vector over time.
module mash_dither_chk
    import mash_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          order,
    input logic [LVL_W-1:0]    level,
    input logic [DITHER_N-1:0] dither_en
);
    AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dither_en) == MID + int'($signed(level))); // R7
    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((dither_en + 1'b1) & dither_en) == '0); // R7
    AST_OFF_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (order == 2'd0) |=> (level == '0)); // R4
    AST_RANGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (order == 2'd1) |=> ($signed(level) >= 0 && $signed(level) <= 1)); // R6
    AST_RANGE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (order == 2'd2) |=> ($signed(level) >= -1 && $signed(level) <= 2)); // R6
    AST_RANGE_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(level) >= -3 && $signed(level) <= 4); // R6
endmodule

bind mash_dither mash_dither_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .order     (order),
    .level     (level),
    .dither_en (dither_en)
);

// File: tb/mash_dither_bench.sv
module mash_dither_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] order;
    logic [4:0] frac_word;
    logic [3:0] level;
    logic [6:0] dither_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference state
    int macc [3];
    int mc2d, mc3d, mc3dd, mlvl, mfq;

    always #4 clk = ~clk;

    mash_dither u_mash_dither (
        .clk(clk), .rst_n(rst_n), .order(order), .frac_word(frac_word),
        .level(level), .dither_en(dither_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // reference model of one edge, using the inputs present at that edge
    task automatic model_step();
        int c [3];
        int s, inw;
        if (!rst_n || order == 2'd0) begin
            for (int k = 0; k < 3; k++) macc[k] = 0;
            mc2d = 0; mc3d = 0; mc3dd = 0; mlvl = 0;
        end else begin
            inw = mfq;
            for (int k = 0; k < 3; k++) begin
                c[k] = 0;
                if (int'(order) > k) begin
                    s = macc[k] + inw;
                    c[k] = s / 32;
                    macc[k] = s % 32;
                    inw = macc[k];
                end
            end
            mlvl = c[0];
            if (order >= 2) begin
                mlvl = mlvl + c[1] - mc2d;
                mc2d = c[1];
            end
            if (order == 3) begin
                mlvl = mlvl + c[2] - 2 * mc3d + mc3dd;
                mc3dd = mc3d;
                mc3d = c[2];
            end
        end
        mfq = rst_n ? int'(frac_word) : 0;
    endtask

    function automatic int lvl_i();
        return int'($signed(level));
    endfunction

    // one clock: advance, update model, compare at the falling edge
    task automatic tick(input string tag);
        int ones;
        @(posedge clk);
        @(negedge clk);
        model_step();
        check(lvl_i() == mlvl, tag, lvl_i(), mlvl);
        ones = $countones(dither_en);
        check(ones == 3 + mlvl && dither_en == 7'((1 << (3 + mlvl)) - 1),
              "R7", int'(dither_en), (1 << (3 + mlvl)) - 1);
    endtask

    initial begin
        int sum, lim, dev, w;
        rst_n = 1'b0; order = 2'd0; frac_word = 5'd0;
        for (int k = 0; k < 3; k++) macc[k] = 0;
        mc2d = 0; mc3d = 0; mc3dd = 0; mlvl = 0; mfq = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick("R1");
        rst_n = 1'b1;
        tick("R1");
        check(level == 4'd0 && dither_en == 7'b0000111, "R1", int'(dither_en), 7);

        // R2: input register latency, from a cleared first-order state
        order = 2'd1; frac_word = 5'd16;
        tick("R2");
        check(lvl_i() == 0, "R2", lvl_i(), 0);
        tick("R2");
        check(lvl_i() == 0, "R2", lvl_i(), 0);
        tick("R2");
        check(lvl_i() == 1, "R2", lvl_i(), 1);

        // Sweep every word at every order
        for (int o = 1; o <= 3; o++) begin
            for (int x = 0; x < 32; x++) begin
                order = 2'd0; frac_word = 5'(x);
                tick("R4");
                check(lvl_i() == 0 && dither_en == 7'b0000111, "R4", lvl_i(), 0);
                order = 2'(o);
                sum = 0;
                for (int n = 0; n < 64; n++) begin
                    tick("R3");
                    sum += lvl_i();
                    if (o == 1) check(lvl_i() >= 0 && lvl_i() <= 1, "R6", lvl_i(), 0);
                    else if (o == 2) check(lvl_i() >= -1 && lvl_i() <= 2, "R6", lvl_i(), 0);
                    else check(lvl_i() >= -3 && lvl_i() <= 4, "R6", lvl_i(), 0);
                    if (o == 1 && n == 31) check(sum == x, "R5", sum, x);
                end
                dev = 32 * sum - 64 * x;
                if (dev < 0) dev = -dev;
                lim = (o == 3) ? 62 : 31;
                check(dev <= lim, "R9", dev, lim);
            end
        end

        // R4: off with a changing word keeps mid-scale
        order = 2'd0;
        for (int i = 0; i < 6; i++) begin
            frac_word = 5'(7 * i + 3);
            tick("R4");
            check(dither_en == 7'b0000111, "R4", int'(dither_en), 7);
        end

        // R8: freeze upper stages mid-sequence and resume
        order = 2'd3; frac_word = 5'd11;
        for (int i = 0; i < 9; i++) tick("R8");
        order = 2'd1;
        for (int i = 0; i < 6; i++) tick("R8");
        order = 2'd2;
        for (int i = 0; i < 5; i++) tick("R8");
        order = 2'd3;
        for (int i = 0; i < 12; i++) tick("R8");

        // Order and word changing on the same edge
        w = 5'd1;
        for (int i = 0; i < 200; i++) begin
            w = ((w * 13) + 7) % 32;
            frac_word = 5'(w);
            if (i % 5 == 0) order = 2'((i / 5) % 3 + 1);
            tick("R3");
        end

        // Reset mid-run returns to mid-scale
        rst_n = 1'b0;
        tick("R1");
        check(level == 4'd0 && dither_en == 7'b0000111, "R1", int'(dither_en), 7);
        finish_run();
    end
endmodule